// File: doc/BRIEF.md
# Port Pad Drive Controller

This block turns a port's latch bits, per-pin mode bits and sensed pad levels into the digital enables that steer one output driver per pin: a pull-down, a strong pull-up, a weak pull-up and a very weak pull-up. It holds the port latch and the two mode registers itself. It also returns each pad's sensed level through a two-stage synchronizer. That synchronized value is both the read-back data and the feedback that keeps the weak pull-up on.

Four drive styles are available per pin. Quasi-bidirectional mode is the one that needs timing. It keeps a very weak pull-up on while the latch is 1. It holds a weak pull-up on only while the pad also reads back high. When the latch goes from 0 to 1 it fires a two-cycle strong pull-up pulse. A parameter mask names pins whose driver is fixed as open drain. An option input picks whether the latch comes out of reset all ones or all zeros. The block is written for a port of `WIDTH` pins and repeats one cell per pin.

Top module: `port_pad_ctrl`

## Requirements
- R1: Mode per pin i is the two-bit value {mode1[i], mode2[i]}: 2'b00 quasi-bidirectional, 2'b01 push-pull, 2'b10 input-only, 2'b11 open drain; mode registers load on `mode_we` and latch bits load on `latch_we`, both at the clock edge.
- R2: In quasi-bidirectional mode the very weak pull-up enable equals the latch bit.
- R3: In quasi-bidirectional mode the weak pull-up enable is on exactly when the latch bit is 1 and the synchronized pad level is 1.
- R4: In quasi-bidirectional mode, a latch bit change from 0 to 1 turns the strong pull-up on for exactly two cycles: the first cycle that shows the new latch value and the one after it.
- R5: In open-drain mode every pull-up is off and the pull-down is on exactly when the latch bit is 0.
- R6: In push-pull mode the strong pull-up equals the latch bit, the pull-down is its inverse, and the weak and very weak pull-ups are off; quasi-bidirectional mode also drives the pull-down when the latch is 0.
- R7: In input-only mode every drive enable is off while the pad level still reaches `pad_rd`.
- R8: Synchronous reset loads every latch bit with `rst_level`, sets every mode to quasi-bidirectional, clears the synchronizer, and fires no strong pulse.
- R9: Pins set in `FORCE_OD` behave as open drain whatever their mode bits hold, and with their latch at 1 they drive nothing, so their pad level can be read.
- R10: The pull-down enable and any pull-up enable of a pin are never on together.
- R11: A mode write that takes a pin out of quasi-bidirectional mode during a strong pulse ends the pulse in the first cycle of the new mode.
- R12: `pad_rd[i]` equals the level of `pad_in[i]` sampled two clock edges earlier, and the weak pull-up uses that synchronized value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_level | input | 1 | Latch value loaded at reset |
| latch_we | input | 1 | Load the port latch |
| latch_wdata | input | WIDTH | New latch bits |
| mode_we | input | 1 | Load both mode registers |
| mode1_wdata | input | WIDTH | Upper mode bit per pin |
| mode2_wdata | input | WIDTH | Lower mode bit per pin |
| pad_in | input | WIDTH | Sensed pad levels |
| pull_dn_en | output | WIDTH | Pull-down enable per pin |
| up_strong_en | output | WIDTH | Strong pull-up enable per pin |
| up_weak_en | output | WIDTH | Weak pull-up enable per pin |
| up_vweak_en | output | WIDTH | Very weak pull-up enable per pin |
| pad_rd | output | WIDTH | Synchronized pad levels |
| latch_rd | output | WIDTH | Current port latch |

## Verification
Random latch writes, mode writes and pad levels run all four modes at once across the port. Each cycle the outputs are compared against a bench model built from the rules above. Directed runs cover these cases:
- A 0-to-1 latch write in quasi-bidirectional mode, which separates a two-cycle pulse from a one-cycle or a stuck one.
- A mode switch in the middle of a pulse, which shows whether the pulse is cut short.
- Reset with each option level.
- Push-pull against open drain with the latch high, which shows whether the forced pins ignore their mode bits.

// File: rtl/pin_drv_pkg.sv
package pin_drv_pkg;

    typedef enum logic [1:0] {
        MODE_QUASI  = 2'b00,
        MODE_PUSH   = 2'b01,
        MODE_INPUT  = 2'b10,
        MODE_ODRAIN = 2'b11
    } pad_mode_e;

    typedef struct packed {
        logic pull_dn;
        logic up_strong;
        logic up_weak;
        logic up_vweak;
    } pad_drive_t;

    localparam int SYNC_STAGES = 2;

    function automatic pad_mode_e resolve_mode(input logic m1, input logic m2,
                                               input logic forced);
        pad_mode_e r;
        if (forced) r = MODE_ODRAIN;
        else        r = pad_mode_e'({m1, m2});
        return r;
    endfunction

    function automatic pad_drive_t decode_drive(input pad_mode_e mode,
                                                input logic latch,
                                                input logic pad_sync,
                                                input logic boost);
        pad_drive_t d;
        d = '0;
        case (mode)
            MODE_QUASI: begin
                d.pull_dn   = ~latch;
                d.up_strong = boost;
                d.up_weak   = latch & pad_sync;
                d.up_vweak  = latch;
            end
            MODE_PUSH: begin
                d.pull_dn   = ~latch;
                d.up_strong = latch;
            end
            MODE_ODRAIN: begin
                d.pull_dn   = ~latch;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    import pin_drv_pkg::*;

    logic [WIDTH-1:0] stage_q [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SYNC_STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < SYNC_STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[SYNC_STAGES-1];

    // R12: two-edge latency once two clean cycles have passed since reset
    p_sync_latency_r12: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (sync_out == $past(async_in, 2)));

endmodule

// File: rtl/pin_boost.sv
module pin_boost (
    input  logic clk,
    input  logic rst,
    input  logic rst_level,
    input  logic latch_q,
    input  logic is_quasi,
    output logic boost_on
);
    logic prev_q;
    logic tail_q;
    logic rise;

    assign rise     = latch_q & ~prev_q;
    assign boost_on = is_quasi & latch_q & (rise | tail_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= rst_level;
            tail_q <= 1'b0;
        end else begin
            prev_q <= latch_q;
            tail_q <= rise & is_quasi;
        end
    end

    // R4: pulse starts in the first cycle the latch shows 1
    p_boost_start_r4: assert property (@(posedge clk) disable iff (rst)
        (is_quasi && latch_q && !$past(latch_q) && !$past(rst)) |-> boost_on);

    // R4: never longer than two cycles
    p_boost_len_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(boost_on) && $past(boost_on, 2)) |-> !boost_on);

endmodule

// File: rtl/pin_cell.sv
module pin_cell #(
    parameter bit FORCED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_level,
    input  logic latch_q,
    input  logic mode1_q,
    input  logic mode2_q,
    input  logic pad_sync,
    output pin_drv_pkg::pad_drive_t drive
);
    import pin_drv_pkg::*;

    pad_mode_e mode_eff;
    logic      boost_on;

    assign mode_eff = resolve_mode(mode1_q, mode2_q, FORCED);

    pin_boost u_boost (
        .clk      (clk),
        .rst      (rst),
        .rst_level(rst_level),
        .latch_q  (latch_q),
        .is_quasi (mode_eff == MODE_QUASI),
        .boost_on (boost_on)
    );

    always_comb drive = decode_drive(mode_eff, latch_q, pad_sync, boost_on);

    p_no_fight_r10: assert property (@(posedge clk) disable iff (rst)
        drive.pull_dn |-> !(drive.up_strong || drive.up_weak || drive.up_vweak));

    p_input_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == MODE_INPUT) |-> (drive == '0));

    p_od_no_pullup_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_eff == MODE_ODRAIN) |-> (!drive.up_strong && !drive.up_weak &&
                                       !drive.up_vweak && drive.pull_dn == !latch_q));

endmodule

// File: rtl/port_pad_ctrl.sv
module port_pad_ctrl #(
    parameter int              WIDTH    = 8,
    parameter logic [WIDTH-1:0] FORCE_OD = 8'b0000_1100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_level,
    input  logic             latch_we,
    input  logic [WIDTH-1:0] latch_wdata,
    input  logic             mode_we,
    input  logic [WIDTH-1:0] mode1_wdata,
    input  logic [WIDTH-1:0] mode2_wdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pull_dn_en,
    output logic [WIDTH-1:0] up_strong_en,
    output logic [WIDTH-1:0] up_weak_en,
    output logic [WIDTH-1:0] up_vweak_en,
    output logic [WIDTH-1:0] pad_rd,
    output logic [WIDTH-1:0] latch_rd
);
    import pin_drv_pkg::*;

    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] mode1_q;
    logic [WIDTH-1:0] mode2_q;
    logic [WIDTH-1:0] pad_sync;

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= {WIDTH{rst_level}};
            mode1_q <= '0;
            mode2_q <= '0;
        end else begin
            if (latch_we) latch_q <= latch_wdata;
            if (mode_we) begin
                mode1_q <= mode1_wdata;
                mode2_q <= mode2_wdata;
            end
        end
    end

    pin_sync #(.WIDTH(WIDTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(pad_in),
        .sync_out(pad_sync)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pad_drive_t drv;

        pin_cell #(.FORCED(FORCE_OD[i])) u_cell (
            .clk      (clk),
            .rst      (rst),
            .rst_level(rst_level),
            .latch_q  (latch_q[i]),
            .mode1_q  (mode1_q[i]),
            .mode2_q  (mode2_q[i]),
            .pad_sync (pad_sync[i]),
            .drive    (drv)
        );

        assign pull_dn_en[i]   = drv.pull_dn;
        assign up_strong_en[i] = drv.up_strong;
        assign up_weak_en[i]   = drv.up_weak;
        assign up_vweak_en[i]  = drv.up_vweak;

        if (FORCE_OD[i]) begin : g_forced
            p_forced_od_r9: assert property (@(posedge clk) disable iff (rst)
                !(up_strong_en[i] || up_weak_en[i] || up_vweak_en[i]));
        end
    end

    assign pad_rd   = pad_sync;
    assign latch_rd = latch_q;

    p_reset_level_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (latch_rd == {WIDTH{$past(rst_level)}} && up_strong_en == '0));

endmodule

// File: tb/sim_port_pad_ctrl.sv
`timescale 1ns/1ps
module sim_port_pad_ctrl;
    localparam int W = 8;
    localparam logic [W-1:0] FOD = 8'b0000_1100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_level = 1'b0;
    logic latch_we = 1'b0;
    logic [W-1:0] latch_wdata = '0;
    logic mode_we = 1'b0;
    logic [W-1:0] mode1_wdata = '0, mode2_wdata = '0, pad_in = '0;
    logic [W-1:0] pull_dn_en, up_strong_en, up_weak_en, up_vweak_en, pad_rd, latch_rd;

    always #4 clk = ~clk;

    port_pad_ctrl #(.WIDTH(W), .FORCE_OD(FOD)) u0 (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // bench model state
    logic [W-1:0] m_latch, m_prev, m_m1, m_m2, m_s1, m_s2, m_tail;

    function automatic logic [1:0] mode_of(int i);
        return FOD[i] ? 2'b11 : {m_m1[i], m_m2[i]};
    endfunction

    // returns {pd, strong, weak, vweak} for bit i
    function automatic logic [3:0] exp_bit(int i);
        logic l, b;
        l = m_latch[i];
        b = l & ((l & ~m_prev[i]) | m_tail[i]);
        case (mode_of(i))
            2'b00: return {~l, b, l & m_s2[i], l};
            2'b01: return {~l, l, 1'b0, 1'b0};
            2'b11: return {~l, 1'b0, 1'b0, 1'b0};
            default: return 4'b0000;
        endcase
    endfunction

    task automatic model_edge();
        logic [W-1:0] new_tail;
        if (rst) begin
            m_latch = {W{rst_level}}; m_prev = {W{rst_level}};
            m_m1 = '0; m_m2 = '0; m_s1 = '0; m_s2 = '0; m_tail = '0;
        end else begin
            for (int i = 0; i < W; i++)
                new_tail[i] = m_latch[i] & ~m_prev[i] & (mode_of(i) == 2'b00);
            m_prev = m_latch;
            if (latch_we) m_latch = latch_wdata;
            if (mode_we) begin m_m1 = mode1_wdata; m_m2 = mode2_wdata; end
            m_s2 = m_s1; m_s1 = pad_in; m_tail = new_tail;
        end
    endtask

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        logic [W-1:0] e_pd, e_st, e_wk, e_vw;
        for (int i = 0; i < W; i++) {e_pd[i], e_st[i], e_wk[i], e_vw[i]} = exp_bit(i);
        chk("R1 R5 R6 pull-down", pull_dn_en, e_pd);
        chk("R4 strong", up_strong_en, e_st);
        chk("R3 weak", up_weak_en, e_wk);
        chk("R2 very weak", up_vweak_en, e_vw);
        chk("R12 read", pad_rd, m_s2);
        chk("R8 latch", latch_rd, m_latch);
        chk("R10 fight", pull_dn_en & (up_strong_en | up_weak_en | up_vweak_en), '0);
    endtask

    // one clock: inputs already driven at negedge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
        latch_we = 0; mode_we = 0;
    endtask

    task automatic wr_latch(logic [W-1:0] v); latch_we = 1; latch_wdata = v; endtask
    task automatic wr_mode(logic [W-1:0] a, logic [W-1:0] b);
        mode_we = 1; mode1_wdata = a; mode2_wdata = b;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!finished) begin
            $display("  %0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        @(negedge clk);
        // R8: reset high
        rst = 1; rst_level = 1; step(); step();
        rst = 0; step();
        chk("R8 latch high", latch_rd, 8'hFF);
        chk("R8 no pulse", up_strong_en, 8'h00);
        chk("R9 forced quiet", up_vweak_en, ~FOD);
        // R8: reset low
        rst = 1; rst_level = 0; step(); step();
        rst = 0; step();
        chk("R8 latch low", latch_rd, 8'h00);
        chk("R8 pd on", pull_dn_en, 8'hFF);

        // R4: two-cycle pulse
        wr_latch(8'hFF); step();
        chk("R4 pulse cycle 1", up_strong_en, ~FOD);
        step();
        chk("R4 pulse cycle 2", up_strong_en, ~FOD);
        step();
        chk("R4 pulse ended", up_strong_en, 8'h00);

        // R11: mode change cuts pulse
        wr_latch(8'h00); step();
        wr_latch(8'hFF); step();
        chk("R11 pulse start", up_strong_en, ~FOD);
        wr_mode(8'hFF, 8'h00); step();
        chk("R11 pulse cut", up_strong_en, 8'h00);
        // R7: input-only, pad still sensed
        pad_in = 8'hA5; step(); step();
        chk("R7 quiet pd", pull_dn_en, 8'h00);
        chk("R7 quiet up", up_vweak_en | up_weak_en, 8'h00);
        chk("R7 sense", pad_rd, 8'hA5);

        // R6 and R9: push-pull request, forced pins stay open drain
        wr_mode(8'h00, 8'hFF); step();
        chk("R6 strong", up_strong_en, ~FOD);
        chk("R6 pd", pull_dn_en, 8'h00);
        chk("R9 forced read", pad_rd & FOD, 8'hA5 & FOD);
        // R5: open drain
        wr_mode(8'hFF, 8'hFF); wr_latch(8'h0F); step();
        chk("R5 pd", pull_dn_en, 8'hF0);
        chk("R5 pull-ups", up_strong_en | up_weak_en | up_vweak_en, 8'h00);
        // R3 and R12: quasi with pad feedback
        wr_mode(8'h00, 8'h00); wr_latch(8'hFF); pad_in = 8'h3C; step(); step(); step();
        chk("R3 weak follows pad", up_weak_en, 8'h3C & ~FOD);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            pad_in = $urandom;
            if ($urandom_range(0, 9) < 3) wr_latch($urandom);
            if ($urandom_range(0, 9) < 1) wr_mode($urandom, $urandom);
            if ($urandom_range(0, 199) == 0) begin rst = 1; rst_level = $urandom; end
            else rst = 0;
            step();
        end

        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule